// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Per-Line Event Detection

This block is a general-purpose I/O peripheral with sixteen lines. Software reaches it through a simple 32-bit register port: a byte address, a write strobe, write data and a combinational read-data bus. Each line has an output value bit and a direction bit. Each line also has a read-only view of its pin, taken after a two-flop synchronizer. The direction register resets to all ones, so every line starts as an input.

Each line has a 3-bit detection style, packed eight fields to a register. The style picks a level-high, level-low, rising-edge, falling-edge or any-transition event. A detected event sets that line's bit in an event-status register, and software clears the bit by writing a one to it. The status bits of lines 0 to 12 drive active-high level interrupt lines. These are placed at fixed positions in a 32-bit parent interrupt vector: lines 0 and 1 go to positions 6 and 7, and lines 2 to 12 go to positions 19 to 29. A clock-select register can turn the top two lines into divided-clock outputs. A further word-wide register only stores a setting for logic outside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Registers are selected by byte address: 0x00 output value, 0x04 direction, 0x08 pin view (read-only), 0x0C event status, 0x10 styles for lines 0–7, 0x14 styles for lines 8–15, 0x18 clock select, 0x1C a stored 32-bit setting. After reset, direction reads 0x0000FFFF and every other register reads 0. An address whose two low bits are not 00 neither writes nor reads (read data 0). Narrow registers read with their upper bits as 0.
- R2: When a line is not in clock mode, `pad_drive[n]` is the inverse of direction bit n (1 = input, 0 = drive), and `pad_out[n]` equals output-value bit n.
- R3: The pin view at 0x08 shows `pad_in` after two clock edges. A change placed before edge k is readable after edge k+1.
- R4: The style of line n sits in bits 3n+2:3n of the 0x10 register for n<8. For n≥8 it sits in bits 3(n−8)+2:3(n−8) of the 0x14 register. Bits 31:24 of both registers are not stored and read as 0.
- R5: Style 0 raises an event on every cycle the synchronized line is high, and style 1 on every cycle it is low. While that condition holds, a clear does not keep the bit at 0.
- R6: Style 2 raises an event on a 0→1 change of the synchronized line, style 3 on a 1→0 change, and style 4 on either. The status bit then stays set until it is cleared.
- R7: Styles 5, 6 and 7 never set a status bit, whatever the pin does.
- R8: Writing a 1 to a bit of 0x0C clears that status bit on the next edge, and writing a 0 leaves it unchanged. If a new event on that line arrives in the same cycle, the bit stays set.
- R9: `irq_o` bit 6+n for n in 0..1, and bit 17+n for n in 2..12, equals status bit n. Every other bit of `irq_o` is 0, so the status bits of lines 13–15 never reach an output.
- R10: Clock select bits 3:0 hold a divisor d, and bit 4 turns line 14 into a clock output. Bits 11:8 and bit 12 do the same for line 15. An enabled line is driven and toggles every d+1 cycles, starting at 0. Other bits are not stored. Writing 0 returns both lines to R2 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pin levels, asynchronous to `clk` |
| pad_out | output | 16 | Value presented to each pin |
| pad_drive | output | 16 | 1 = the pin is driven with `pad_out` |
| irq_o | output | 32 | Level-high parent interrupt vector |

## Verification
Most internal faults show up at the ports within one or two clocks. A wrong synchronizer stage moves the pin view and every event by one cycle. A misplaced style field makes the wrong line respond, and a mishandled clear shows as an interrupt bit that drops too early or stays up. A reference model in the bench follows the registers, the synchronizer, the event logic and the clock dividers cycle by cycle. It compares the read bus, the pad outputs and the full interrupt vector after every edge, so a fault is caught on the first cycle it appears. Directed sequences then exercise each style, clearing during an active level, the reserved style codes, the lines that cannot interrupt, and the clock outputs.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int STYLE_W       = 3;
    localparam int LINES_PER_REG = 8;

    // Detection style codes; the remaining codes are inert
    typedef enum logic [STYLE_W-1:0] {
        STY_LEVEL_HI = 3'd0,
        STY_LEVEL_LO = 3'd1,
        STY_RISE     = 3'd2,
        STY_FALL     = 3'd3,
        STY_TOGGLE   = 3'd4
    } style_e;

    // Word index of each register (byte address >> 2)
    typedef enum logic [2:0] {
        RG_DOUT   = 3'd0,
        RG_DIR    = 3'd1,
        RG_PIN    = 3'd2,
        RG_EVT    = 3'd3,
        RG_STY_LO = 3'd4,
        RG_STY_HI = 3'd5,
        RG_CLKSEL = 3'd6,
        RG_AUX    = 3'd7
    } reg_idx_e;

    // Position of a line's interrupt in the parent vector
    function automatic int parent_irq_num(input int line);
        return (line < 2) ? (6 + line) : (17 + line);
    endfunction

endpackage

// File: rtl/gpio_line_detect.sv
`timescale 1ns/1ps
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_i,
    input  logic [STYLE_W-1:0] style_i,
    output logic               level_o,
    output logic               event_o
);

    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } det_t;

    det_t det_d, det_q;
    logic rise, fall;

    always_comb begin
        det_d.meta   = pin_i;
        det_d.stable = det_q.meta;
        det_d.prev   = det_q.stable;
        rise = det_q.stable & ~det_q.prev;
        fall = ~det_q.stable & det_q.prev;
        case (style_i)
            STY_LEVEL_HI: event_o = det_q.stable;
            STY_LEVEL_LO: event_o = ~det_q.stable;
            STY_RISE:     event_o = rise;
            STY_FALL:     event_o = fall;
            STY_TOGGLE:   event_o = rise | fall;
            default:      event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign level_o = det_q.stable;

endmodule

// File: rtl/gpio_clk_div.sv
`timescale 1ns/1ps
module gpio_clk_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             phase;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!en_i) begin
            div_d = '0;
        end else if (div_q.cnt == div_i) begin
            div_d.cnt   = '0;
            div_d.phase = ~div_q.phase;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign clk_o = div_q.phase;

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IRQ_LINES = 13,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int PARENT_W  = 32,
    parameter int DIV_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_drive,
    output logic [PARENT_W-1:0]  irq_o
);

    localparam int STY_W      = LINES_PER_REG * STYLE_W;
    localparam int N_CLK      = 2;
    localparam int CLK_STRIDE = 8;
    localparam int CLKSEL_W   = N_CLK * CLK_STRIDE;
    localparam int CLK_BASE   = NUM_LINES - N_CLK;

    function automatic logic [CLKSEL_W-1:0] clksel_mask();
        logic [CLKSEL_W-1:0] m;
        m = '0;
        for (int k = 0; k < N_CLK; k++) m[k*CLK_STRIDE +: DIV_W+1] = '1;
        return m;
    endfunction

    localparam logic [CLKSEL_W-1:0] CLKSEL_MASK = clksel_mask();

    typedef struct packed {
        logic [NUM_LINES-1:0] dout;
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] status;
        logic [STY_W-1:0]     sty_lo;
        logic [STY_W-1:0]     sty_hi;
        logic [CLKSEL_W-1:0]  clksel;
        logic [DATA_W-1:0]    aux;
    } regs_t;

    localparam regs_t REGS_RST = '{
        dout: '0, dir: '1, status: '0, sty_lo: '0,
        sty_hi: '0, clksel: '0, aux: '0
    };

    regs_t r_d, r_q;

    logic [NUM_LINES-1:0] line_evt;
    logic [NUM_LINES-1:0] line_lvl;
    logic [STYLE_W-1:0]   line_sty [NUM_LINES];
    logic [N_CLK-1:0]     gen_en;
    logic [N_CLK-1:0]     gen_clk;
    logic [NUM_LINES-1:0] clr_bits;
    logic [2:0]           word_idx;
    logic                 aligned;

    assign word_idx = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);

    // Per-line synchronizer and event detector
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g < LINES_PER_REG) begin : g_lo
            assign line_sty[g] = r_q.sty_lo[g*STYLE_W +: STYLE_W];
        end else begin : g_hi
            assign line_sty[g] = r_q.sty_hi[(g-LINES_PER_REG)*STYLE_W +: STYLE_W];
        end
        gpio_line_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pad_in[g]),
            .style_i (line_sty[g]),
            .level_o (line_lvl[g]),
            .event_o (line_evt[g])
        );
    end

    // Clock generators for the top lines
    for (genvar k = 0; k < N_CLK; k++) begin : g_clk
        assign gen_en[k] = r_q.clksel[k*CLK_STRIDE + DIV_W];
        gpio_clk_div #(.DIV_W(DIV_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (gen_en[k]),
            .div_i (r_q.clksel[k*CLK_STRIDE +: DIV_W]),
            .clk_o (gen_clk[k])
        );
    end

    // Next-state computation
    always_comb begin
        r_d      = r_q;
        clr_bits = '0;
        if (bus_wr_en && aligned) begin
            case (reg_idx_e'(word_idx))
                RG_DOUT:   r_d.dout   = bus_wdata[NUM_LINES-1:0];
                RG_DIR:    r_d.dir    = bus_wdata[NUM_LINES-1:0];
                RG_EVT:    clr_bits   = bus_wdata[NUM_LINES-1:0];
                RG_STY_LO: r_d.sty_lo = bus_wdata[STY_W-1:0];
                RG_STY_HI: r_d.sty_hi = bus_wdata[STY_W-1:0];
                RG_CLKSEL: r_d.clksel = bus_wdata[CLKSEL_W-1:0] & CLKSEL_MASK;
                RG_AUX:    r_d.aux    = bus_wdata;
                default:   ;
            endcase
        end
        // a fresh event outranks a clear in the same cycle
        r_d.status = (r_q.status & ~clr_bits) | line_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (reg_idx_e'(word_idx))
                RG_DOUT:   bus_rdata[NUM_LINES-1:0] = r_q.dout;
                RG_DIR:    bus_rdata[NUM_LINES-1:0] = r_q.dir;
                RG_PIN:    bus_rdata[NUM_LINES-1:0] = line_lvl;
                RG_EVT:    bus_rdata[NUM_LINES-1:0] = r_q.status;
                RG_STY_LO: bus_rdata[STY_W-1:0]     = r_q.sty_lo;
                RG_STY_HI: bus_rdata[STY_W-1:0]     = r_q.sty_hi;
                RG_CLKSEL: bus_rdata[CLKSEL_W-1:0]  = r_q.clksel;
                RG_AUX:    bus_rdata                = r_q.aux;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // Pad outputs with clock override
    always_comb begin
        pad_out   = r_q.dout;
        pad_drive = ~r_q.dir;
        for (int k = 0; k < N_CLK; k++) begin
            if (gen_en[k]) begin
                pad_out[CLK_BASE+k]   = gen_clk[k];
                pad_drive[CLK_BASE+k] = 1'b1;
            end
        end
    end

    // Parent interrupt placement
    always_comb begin
        irq_o = '0;
        for (int l = 0; l < IRQ_LINES; l++) irq_o[parent_irq_num(l)] = r_q.status[l];
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IRQ_LINES = 13,
    parameter int PARENT_W  = 32,
    parameter int CLKSEL_W  = 16,
    parameter int N_CLK     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr_en,
    input logic [4:0]           bus_addr,
    input logic [NUM_LINES-1:0] clr_data,
    input logic [PARENT_W-1:0]  irq_o,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_drive,
    input logic [NUM_LINES-1:0] status_q,
    input logic [STYLE_W-1:0]   sty0_q,
    input logic [NUM_LINES-1:0] dout_q,
    input logic [NUM_LINES-1:0] dir_q,
    input logic [CLKSEL_W-1:0]  clksel_q
);

    localparam int CLK_BASE = NUM_LINES - N_CLK;

    logic clear_hit;
    assign clear_hit = bus_wr_en && (bus_addr == 5'h0C);

    // R7
    reserved_style_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sty0_q >= 3'd5) |=> !$rose(status_q[0]));

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_hold
        // R8
        status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_q[l] && !(clear_hit && clr_data[l])) |=> status_q[l]);
    end

    for (genvar l = 0; l < IRQ_LINES; l++) begin : g_irq
        // R9
        irq_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_o[parent_irq_num(l)]) |-> $past(clear_hit && clr_data[l]));
    end

    for (genvar l = 0; l < CLK_BASE; l++) begin : g_dir
        // R2
        input_not_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dir_q[l] |-> !pad_drive[l]);
    end

    // R10
    clock_off_plain_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clksel_q == '0) |-> (pad_out[NUM_LINES-1:CLK_BASE] == dout_q[NUM_LINES-1:CLK_BASE]
                              && pad_drive[NUM_LINES-1:CLK_BASE] == ~dir_q[NUM_LINES-1:CLK_BASE]));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .IRQ_LINES (IRQ_LINES),
    .PARENT_W  (PARENT_W),
    .CLKSEL_W  (CLKSEL_W),
    .N_CLK     (N_CLK)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .clr_data  (bus_wdata[NUM_LINES-1:0]),
    .irq_o     (irq_o),
    .pad_out   (pad_out),
    .pad_drive (pad_drive),
    .status_q  (r_q.status),
    .sty0_q    (r_q.sty_lo[2:0]),
    .dout_q    (r_q.dout),
    .dir_q     (r_q.dir),
    .clksel_q  (r_q.clksel)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_drive;
    logic [31:0] irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_drive(pad_drive), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [15:0] m_out = '0, m_dir = '1, m_s1 = '0, m_s2 = '0, m_prev = '0, m_stat = '0;
    logic [23:0] m_lo = '0, m_hi = '0;
    logic [15:0] m_csel = '0;
    logic [31:0] m_aux = '0;
    logic [3:0]  m_cnt [2];
    logic        m_ck  [2];
    initial begin m_cnt[0] = 0; m_cnt[1] = 0; m_ck[0] = 0; m_ck[1] = 0; end

    function automatic logic [2:0] m_style(input int l);
        return (l < 8) ? m_lo[l*3 +: 3] : m_hi[(l-8)*3 +: 3];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = '0; m_dir = '1; m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            m_lo = '0; m_hi = '0; m_csel = '0; m_aux = '0;
            for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_ck[k] = 0; end
        end else begin
            logic [15:0] ev, clr;
            ev = '0; clr = '0;
            for (int l = 0; l < 16; l++) begin
                bit c, p;
                c = m_s2[l]; p = m_prev[l];
                case (m_style(l))
                    3'd0: ev[l] = c;
                    3'd1: ev[l] = !c;
                    3'd2: ev[l] = c && !p;
                    3'd3: ev[l] = !c && p;
                    3'd4: ev[l] = c != p;
                    default: ev[l] = 1'b0;
                endcase
            end
            for (int k = 0; k < 2; k++) begin
                if (!m_csel[8*k+4]) begin m_cnt[k] = 0; m_ck[k] = 0; end
                else if (m_cnt[k] == m_csel[8*k +: 4]) begin m_cnt[k] = 0; m_ck[k] = !m_ck[k]; end
                else m_cnt[k] = m_cnt[k] + 1;
            end
            if (wr_en && addr[1:0] == 2'b00) begin
                case (addr[4:2])
                    3'd0: m_out  = wdata[15:0];
                    3'd1: m_dir  = wdata[15:0];
                    3'd3: clr    = wdata[15:0];
                    3'd4: m_lo   = wdata[23:0];
                    3'd5: m_hi   = wdata[23:0];
                    3'd6: m_csel = wdata[15:0] & 16'h1F1F;
                    3'd7: m_aux  = wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clr) | ev;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[4:2])
            3'd0: return {16'h0, m_out};
            3'd1: return {16'h0, m_dir};
            3'd2: return {16'h0, m_s2};
            3'd3: return {16'h0, m_stat};
            3'd4: return {8'h0, m_lo};
            3'd5: return {8'h0, m_hi};
            3'd6: return {16'h0, m_csel};
            default: return m_aux;
        endcase
    endfunction

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            logic [31:0] e_irq;
            logic [15:0] e_po, e_pd;
            e_irq = '0;
            for (int l = 0; l < 13; l++) e_irq[(l < 2) ? 6 + l : 17 + l] = m_stat[l];
            e_po = m_out; e_pd = ~m_dir;
            for (int k = 0; k < 2; k++)
                if (m_csel[8*k+4]) begin e_po[14+k] = m_ck[k]; e_pd[14+k] = 1'b1; end
            chk("R9 irq vector", irq, e_irq);
            chk("R2 pad_out", {16'h0, pad_out}, {16'h0, e_po});
            chk("R2 pad_drive", {16'h0, pad_drive}, {16'h0, e_pd});
            chk("R1 read data", rdata, m_read(addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); wr_en = 1'b0; addr = a; #4;
        chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] sty_fill(input int code);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 8; i++) w[i*3 +: 3] = code[2:0];
        return w;
    endfunction

    function automatic logic [31:0] sty_set(input logic [31:0] w, input int slot, input int code);
        logic [31:0] r;
        r = w;
        r[slot*3 +: 3] = code[2:0];
        return r;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int tog;
        logic prevb;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h04, 32'h0000FFFF, "R1 direction reset");
        bus_read(5'h00, 32'h0, "R1 output reset");
        bus_read(5'h0C, 32'h0, "R1 status reset");
        bus_read(5'h18, 32'h0, "R1 clksel reset");
        bus_write(5'h1C, 32'hDEADBEEF);
        bus_read(5'h1C, 32'hDEADBEEF, "R1 aux readback");
        bus_write(5'h1D, 32'h12345678);
        bus_read(5'h1C, 32'hDEADBEEF, "R1 misaligned write ignored");
        bus_read(5'h1D, 32'h0, "R1 misaligned read zero");

        // R2 output and direction
        bus_write(5'h00, 32'h0000A5A5);
        bus_write(5'h04, 32'h00000F0F);
        @(negedge clk); #4;
        chk("R2 pad_out value", {16'h0, pad_out}, 32'h0000A5A5);
        chk("R2 pad_drive value", {16'h0, pad_drive}, 32'h0000F0F0);

        // R4 field layout, reserved styles everywhere
        bus_write(5'h10, 32'hFF000000 | sty_fill(5));
        bus_read(5'h10, sty_fill(5), "R4 upper bits not stored");
        bus_write(5'h14, sty_fill(5));

        // R3 two-stage synchronizer
        @(negedge clk); pad_in = 16'h1234; addr = 5'h08; #4;
        chk("R3 pin view before edges", rdata, 32'h0);
        @(negedge clk); #4;
        chk("R3 pin view after one edge", rdata, 32'h0);
        @(negedge clk); #4;
        chk("R3 pin view after two edges", rdata, 32'h1234);

        // R7 reserved codes 5,6,7
        for (int i = 0; i < 4; i++) begin pad_in = ~pad_in; idle(2); end
        bus_write(5'h10, sty_fill(6));
        bus_write(5'h14, sty_fill(7));
        for (int i = 0; i < 4; i++) begin pad_in = ~pad_in; idle(2); end
        bus_read(5'h0C, 32'h0, "R7 reserved styles inert");
        bus_write(5'h10, sty_fill(5));
        bus_write(5'h14, sty_fill(5));

        // R6 rising on line 3
        pad_in = 16'h0; idle(3);
        bus_write(5'h10, sty_set(sty_fill(5), 3, 2));
        pad_in = 16'h0008; idle(3);
        bus_read(5'h0C, 32'h0008, "R6 rising sets status");
        chk("R9 line3 to parent 20", irq, 32'h0010_0000);
        pad_in = 16'h0; idle(3);
        bus_read(5'h0C, 32'h0008, "R6 status latched after fall");
        bus_write(5'h0C, 32'h0000_0000);
        bus_read(5'h0C, 32'h0008, "R8 write zero keeps bit");
        bus_write(5'h0C, 32'h0000_0008);
        bus_read(5'h0C, 32'h0, "R8 write one clears");

        // R6 falling on line 3
        bus_write(5'h10, sty_set(sty_fill(5), 3, 3));
        pad_in = 16'h0008; idle(3);
        bus_read(5'h0C, 32'h0, "R6 falling ignores rise");
        pad_in = 16'h0; idle(3);
        bus_read(5'h0C, 32'h0008, "R6 falling sets status");
        bus_write(5'h0C, 32'h0000FFFF);

        // R6 any transition on line 9 (upper register slot 1)
        bus_write(5'h14, sty_set(sty_fill(5), 1, 4));
        pad_in = 16'h0200; idle(3);
        bus_read(5'h0C, 32'h0200, "R6 toggle on rise");
        chk("R9 line9 to parent 26", irq, 32'h0400_0000);
        bus_write(5'h0C, 32'h0000_0200);
        pad_in = 16'h0; idle(3);
        bus_read(5'h0C, 32'h0200, "R6 toggle on fall");
        bus_write(5'h0C, 32'h0000_0200);
        bus_write(5'h14, sty_fill(5));

        // R5 level low on line 0, clear while active
        bus_write(5'h10, sty_set(sty_fill(5), 0, 1));
        idle(2);
        bus_read(5'h0C, 32'h0001, "R5 level low sets");
        bus_write(5'h0C, 32'h0000_0001);
        bus_read(5'h0C, 32'h0001, "R5 clear does not stick while active");
        chk("R9 line0 to parent 6", irq, 32'h0000_0040);
        pad_in = 16'h0001; idle(3);
        bus_write(5'h0C, 32'h0000_0001);
        bus_read(5'h0C, 32'h0, "R5 clear after inactive");

        // R5 level high on line 1, R8 event wins over clear
        bus_write(5'h10, sty_set(sty_fill(5), 1, 0));
        pad_in = 16'h0002; idle(3);
        bus_write(5'h0C, 32'h0000_0002);
        bus_read(5'h0C, 32'h0002, "R8 event wins over clear");
        chk("R9 line1 to parent 7", irq, 32'h0000_0080);
        pad_in = 16'h0; idle(3);
        bus_write(5'h0C, 32'h0000_0002);
        bus_write(5'h10, sty_fill(5));

        // R9 lines 13..15 latch status but raise nothing
        bus_write(5'h14, sty_set(sty_set(sty_set(sty_fill(5), 5, 0), 6, 0), 7, 0));
        pad_in = 16'hE000; idle(3);
        bus_read(5'h0C, 32'h0000E000, "R9 upper lines latch status");
        chk("R9 upper lines no interrupt", irq, 32'h0);
        bus_write(5'h14, sty_fill(5));
        pad_in = 16'h0; idle(3);
        bus_write(5'h0C, 32'h0000FFFF);

        // R10 clock outputs
        bus_write(5'h04, 32'h0000FFFF);
        bus_write(5'h18, 32'hFFFFFFFF);
        bus_read(5'h18, 32'h00001F1F, "R10 clksel stored bits");
        bus_write(5'h18, 32'h0);
        bus_write(5'h18, 32'h00000012);
        tog = 0; prevb = pad_out[14];
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); #4;
            if (pad_out[14] !== prevb) tog++;
            prevb = pad_out[14];
        end
        chk("R10 line14 toggles every 3 cycles", tog, 32'd3);
        chk("R10 line14 driven", {31'h0, pad_drive[14]}, 32'h1);
        bus_write(5'h18, 32'h00001012);
        idle(6);
        bus_write(5'h18, 32'h0);
        @(negedge clk); #4;
        chk("R10 return to plain GPIO drive", {30'h0, pad_drive[15:14]}, 32'h0);
        chk("R10 return to plain GPIO value", {30'h0, pad_out[15:14]}, 32'h2);

        idle(2);
        finish_run();
    end

endmodule